// File: doc/BRIEF.md
# Serial Link Response Poller

This block takes over a single-wire, active-low serial data line once a command frame has gone out to a slave device. It clocks the link one bit per core cycle and hunts for a response start bit. It then decodes the slave's 2-bit id and 2-bit response code. On an acknowledge it gathers the read data, when there is any, and then checks a 4-bit trailing checksum. A busy slave is handled by the block itself: it drives the line idle for a settling gap, sends a fixed data-poll frame, waits out an echo interval and listens again. The number of retries is bounded.

The surrounding controller pulses `start` along with the transfer direction and size. It then waits for the one-cycle `done` pulse. At that point `err` holds a 3-bit result code and `rd_data` holds the captured data, and both stay stable until the next `start`. Every cycle in which the link clock is active is reported on `link_clk`. The block also provides the driven level and drive enable for the data pin.

Top module: `resp_poller`

## Requirements
- R1: A `start` pulse while idle launches a transaction. From the next cycle `link_clk` is 1 every cycle until `done`. While listening, the logical bit is the inverse of `line_in`, sampled once per `link_clk` cycle, and the first logical 1 is the start bit.
- R2: After 1000 consecutive logical-0 samples with no start bit, the block clocks 20 further discarded bits and ends with `err` = 4, for a total of 1020 link clocks. A start bit on sample 1000 (999 zeros before it) is still accepted.
- R3: The 4 bits after the start bit are the slave id (2 bits) followed by the response code (2 bits), both MSB first. Code 0 is acknowledge, 1 busy, 2 general error, 3 slave-detected checksum error.
- R4: On an acknowledge to a read, 8, 16 or 32 data bits follow, MSB first, for `rd_size` 0, 1 or 2/3. They are returned right-aligned in `rd_data` with zeros above.
- R5: On an acknowledge to a write no data bits are received, and the 4 checksum bits follow the response code directly.
- R6: The checksum starts from 0. For each bit b, starting with the start bit and continuing through the id, the code and the data, the step is: m = b XOR c[3], c = {c[2:0],0} XOR {0,m,m,m}. It is compared with the 4 received bits (MSB first). A mismatch gives `err` = 5, and the read data is still returned.
- R7: On busy, the block drives `line_oe` for 126 link clocks. These carry 100 logical 0s, then the start bit 1 followed by the 9-bit value 0x2A MSB first, then 16 logical 0s. After that it listens for a new response with a fresh 1000-clock timeout.
- R8: Up to 100 busy responses are retried. The 101st busy response ends the transaction at once, with no poll and no drain, with `err` = 1.
- R9: Response code 2 or 3 is followed by 20 discarded bits and ends with `err` = 2 or 3. No checksum is read.
- R10: After a complete acknowledge and checksum, the block issues 100 more link clocks before `done`.
- R11: `done` is a single-cycle pulse in the cycle after the last link clock. `err` is 0 on success. `err` and `rd_data` hold their values until the next `start`.
- R12: `start`, `is_read` and `rd_size` are ignored while a transaction is running.
- R13: `line_out` carries the inverse of the logical bit being sent and is 1 whenever `line_oe` is 0. `line_oe` is asserted only during the busy gap, the poll frame and the echo interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one link bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin waiting for a response |
| is_read | input | 1 | 1 if the command sent was a read |
| rd_size | input | 2 | Data size: 0 byte, 1 halfword, 2/3 word |
| line_in | input | 1 | Data line level (active low) |
| link_clk | output | 1 | Link clock active this cycle |
| line_oe | output | 1 | Drive enable for the data line |
| line_out | output | 1 | Driven data line level (active low) |
| done | output | 1 | Transaction complete pulse |
| err | output | 3 | Result: 0 ok, 1 busy limit, 2 error response, 3 slave checksum error, 4 timeout, 5 checksum mismatch |
| rd_data | output | 32 | Captured read data, right-aligned |

## Verification
The bench targets the off-by-one edges of the timeout window. A start bit after 999 idle bits must succeed and one after 1000 must not, so a counter that compares one step early or late fails one of the two. It drives exactly 100 and then 101 busy responses, which catches a retry limit that is one off and a final busy that wrongly sends a poll or drains. It also checks every bit of the poll frame, including the start bit and the settling and echo gaps. It corrupts the checksum of random transfers to confirm that the error flag is raised while the data is still delivered. Total link clock counts per transaction expose any missing or extra drain and priming clocks.

// File: rtl/resp_poller_pkg.sv
package resp_poller_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_WAIT, S_HDR, S_DATA, S_CRC,
        S_PRE, S_POLL, S_ECHO, S_DRAIN, S_PRIME
    } state_e;

    typedef enum logic [2:0] {
        E_NONE = 3'd0,
        E_BUSY = 3'd1,
        E_RSP  = 3'd2,
        E_SCRC = 3'd3,
        E_TMO  = 3'd4,
        E_MCRC = 3'd5
    } err_e;

    localparam logic [1:0] RC_ACK  = 2'd0;
    localparam logic [1:0] RC_BUSY = 2'd1;
    localparam logic [1:0] RC_ERR  = 2'd2;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/resp_poller_crc4.sv
module resp_poller_crc4 (
    input  logic [3:0] crc_i,
    input  logic       bit_i,
    output logic [3:0] crc_o
);
    logic fb;
    assign fb    = bit_i ^ crc_i[3];
    assign crc_o = {crc_i[2:0], 1'b0} ^ {1'b0, fb, fb, fb};
endmodule

// File: rtl/resp_poller_pollbit.sv
module resp_poller_pollbit #(
    parameter int          POLL_W   = 9,
    parameter logic [31:0] POLL_VAL = 32'h2A,
    parameter int          IDX_W    = 10
) (
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam logic [POLL_W:0] FRAME = {1'b1, POLL_VAL[POLL_W-1:0]};

    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i <= POLL_W; i++) begin
            if (idx == IDX_W'(i)) bit_o = FRAME[POLL_W-i];
        end
    end
endmodule

// File: rtl/resp_poller.sv
module resp_poller
    import resp_poller_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          TMO_CLKS   = 1000,
    parameter int          MAX_BUSY   = 100,
    parameter int          PRE_CLKS   = 100,
    parameter int          ECHO_CLKS  = 16,
    parameter int          DRAIN_BITS = 20,
    parameter int          PRIME_CLKS = 100,
    parameter int          POLL_W     = 9,
    parameter logic [31:0] POLL_VAL   = 32'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic [1:0]        rd_size,
    input  logic              line_in,
    output logic              link_clk,
    output logic              line_oe,
    output logic              line_out,
    output logic              done,
    output logic [2:0]        err,
    output logic [DATA_W-1:0] rd_data
);
    localparam int CNT_MAX = imax(imax(imax(TMO_CLKS, PRE_CLKS), imax(ECHO_CLKS, DRAIN_BITS)),
                                  imax(imax(PRIME_CLKS, DATA_W), POLL_W + 1));
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BSY_W   = $clog2(MAX_BUSY + 1);

    typedef struct packed {
        state_e            st;
        logic [CNT_W-1:0]  cnt;
        logic [BSY_W-1:0]  nbusy;
        logic [DATA_W-1:0] data;
        logic [3:0]        crc;
        logic [2:0]        rxc;
        logic              prev;
        logic              rd;
        logic [1:0]        sz;
        err_e              err;
        logic              done;
    } regs_t;

    regs_t q, d;

    logic             rx_bit;
    logic [3:0]       crc_in, crc_nx;
    logic             poll_bit;
    logic [CNT_W-1:0] data_last;

    assign rx_bit = ~line_in;
    assign crc_in = (q.st == S_WAIT) ? 4'h0 : q.crc;

    resp_poller_crc4 u_crc (
        .crc_i (crc_in),
        .bit_i (rx_bit),
        .crc_o (crc_nx)
    );

    resp_poller_pollbit #(
        .POLL_W   (POLL_W),
        .POLL_VAL (POLL_VAL),
        .IDX_W    (CNT_W)
    ) u_poll (
        .idx   (q.cnt),
        .bit_o (poll_bit)
    );

    always_comb begin
        case (q.sz)
            2'd0:    data_last = CNT_W'(7);
            2'd1:    data_last = CNT_W'(15);
            default: data_last = CNT_W'(DATA_W - 1);
        endcase
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (q.st != S_IDLE) d.cnt = q.cnt + 1'b1;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st    = S_WAIT;
                    d.cnt   = '0;
                    d.nbusy = '0;
                    d.rd    = is_read;
                    d.sz    = rd_size;
                    d.err   = E_NONE;
                    d.data  = '0;
                end
            end
            S_WAIT: begin
                if (rx_bit) begin
                    d.st  = S_HDR;
                    d.cnt = '0;
                    d.crc = crc_nx;
                end else if (q.cnt == CNT_W'(TMO_CLKS - 1)) begin
                    d.st  = S_DRAIN;
                    d.cnt = '0;
                    d.err = E_TMO;
                end
            end
            S_HDR: begin
                d.prev = rx_bit;
                d.crc  = crc_nx;
                if (q.cnt == CNT_W'(3)) begin
                    d.cnt = '0;
                    case ({q.prev, rx_bit})
                        RC_ACK:  d.st = q.rd ? S_DATA : S_CRC;
                        RC_BUSY: begin
                            if (q.nbusy == BSY_W'(MAX_BUSY)) begin
                                d.st   = S_IDLE;
                                d.err  = E_BUSY;
                                d.done = 1'b1;
                            end else begin
                                d.nbusy = q.nbusy + 1'b1;
                                d.st    = S_PRE;
                            end
                        end
                        RC_ERR: begin
                            d.st  = S_DRAIN;
                            d.err = E_RSP;
                        end
                        default: begin
                            d.st  = S_DRAIN;
                            d.err = E_SCRC;
                        end
                    endcase
                end
            end
            S_DATA: begin
                d.data = {q.data[DATA_W-2:0], rx_bit};
                d.crc  = crc_nx;
                if (q.cnt == data_last) begin
                    d.st  = S_CRC;
                    d.cnt = '0;
                end
            end
            S_CRC: begin
                d.rxc = {q.rxc[1:0], rx_bit};
                if (q.cnt == CNT_W'(3)) begin
                    if ({q.rxc, rx_bit} != q.crc) d.err = E_MCRC;
                    d.st  = S_PRIME;
                    d.cnt = '0;
                end
            end
            S_PRE: begin
                if (q.cnt == CNT_W'(PRE_CLKS - 1)) begin
                    d.st  = S_POLL;
                    d.cnt = '0;
                end
            end
            S_POLL: begin
                if (q.cnt == CNT_W'(POLL_W)) begin
                    d.st  = S_ECHO;
                    d.cnt = '0;
                end
            end
            S_ECHO: begin
                if (q.cnt == CNT_W'(ECHO_CLKS - 1)) begin
                    d.st  = S_WAIT;
                    d.cnt = '0;
                end
            end
            S_DRAIN: begin
                if (q.cnt == CNT_W'(DRAIN_BITS - 1)) begin
                    d.st   = S_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                end
            end
            S_PRIME: begin
                if (q.cnt == CNT_W'(PRIME_CLKS - 1)) begin
                    d.st   = S_IDLE;
                    d.cnt  = '0;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign link_clk = (q.st != S_IDLE);
    assign line_oe  = (q.st == S_PRE) || (q.st == S_POLL) || (q.st == S_ECHO);
    assign line_out = ~((q.st == S_POLL) & poll_bit);
    assign done     = q.done;
    assign err      = q.err;
    assign rd_data  = q.data;

endmodule

// File: rtl/resp_poller_chk.sv
module resp_poller_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              link_clk,
    input logic              line_oe,
    input logic              line_out,
    input logic              done,
    input logic [2:0]        err,
    input logic [DATA_W-1:0] rd_data
);
    AST_START_LAUNCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !link_clk) |=> link_clk) else $error("launch"); // R1

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done pulse"); // R11

    AST_DONE_AFTER_CLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!link_clk && $past(link_clk))) else $error("done timing"); // R11

    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_clk && !start) |=> ($stable(err) && $stable(rd_data))) else $error("hold"); // R11

    AST_DRIVE_IN_TXN: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> link_clk) else $error("drive"); // R13

    AST_RELEASED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> line_out) else $error("level"); // R13

    AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err <= 3'd5)) else $error("code"); // R11
endmodule

bind resp_poller resp_poller_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .link_clk (link_clk),
    .line_oe  (line_oe),
    .line_out (line_out),
    .done     (done),
    .err      (err),
    .rd_data  (rd_data)
);

// File: tb/test_resp_poller.sv
module test_resp_poller;
    logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, is_read = 1'b0, line_in = 1'b1;
    logic [1:0]  rd_size = 2'd0;
    logic        link_clk, line_oe, line_out, done;
    logic [2:0]  err;
    logic [31:0] rd_data;

    always #5 clk = ~clk;

    resp_poller i_resp_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read), .rd_size(rd_size),
        .line_in(line_in), .link_clk(link_clk), .line_oe(line_oe), .line_out(line_out),
        .done(done), .err(err), .rd_data(rd_data)
    );

    int checks = 0, errors = 0;
    bit stream [16384];
    int wr_ptr = 0, rd_ptr = 0, ticks = 0, oe_ticks = 0;
    bit txlog [1024];
    bit hung = 0;

    // slave model: present the next scripted bit for each listening clock
    always @(negedge clk) begin
        if (link_clk) ticks++;
        if (link_clk && line_oe) begin
            txlog[oe_ticks % 1024] = ~line_out;
            oe_ticks++;
        end
        if (link_clk && !line_oe) begin
            line_in <= ~((rd_ptr < wr_ptr) ? stream[rd_ptr % 16384] : 1'b0);
            rd_ptr++;
        end else begin
            line_in <= 1'b1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] cstep(input logic [3:0] c, input bit b);
        logic m;
        m = b ^ c[3];
        return {c[2:0], 1'b0} ^ {1'b0, m, m, m};
    endfunction

    task automatic push(input bit b);
        stream[wr_ptr % 16384] = b;
        wr_ptr++;
    endtask

    task automatic add_resp(input int gap, input bit [1:0] id, input bit [1:0] code,
                            input int nbits, input bit [31:0] dat, input bit bad);
        logic [3:0] c;
        for (int i = 0; i < gap; i++) push(1'b0);
        push(1'b1);
        c = cstep(4'h0, 1'b1);
        for (int i = 1; i >= 0; i--) begin push(id[i]); c = cstep(c, id[i]); end
        for (int i = 1; i >= 0; i--) begin push(code[i]); c = cstep(c, code[i]); end
        if (code != 2'd0) return;
        for (int i = nbits - 1; i >= 0; i--) begin push(dat[i]); c = cstep(c, dat[i]); end
        if (bad) c = c ^ 4'h5;
        for (int i = 3; i >= 0; i--) push(c[i]);
    endtask

    function automatic int nb(input bit [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    task automatic clear_stream();
        wr_ptr = rd_ptr;
    endtask

    task automatic run(input bit rd, input bit [1:0] sz, input bit poke,
                       output int tk, output int oe, output int e, output int dat);
        int t0, o0, w;
        @(negedge clk);
        is_read = rd; rd_size = sz; start = 1'b1;
        t0 = ticks; o0 = oe_ticks;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 50000) begin
            @(negedge clk);
            w++;
            if (poke && w == 10) begin start = 1'b1; is_read = ~rd; rd_size = 2'd2; end
            else start = 1'b0;
        end
        if (!done) begin
            hung = 1;
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
        end
        tk = ticks - t0; oe = oe_ticks - o0; e = int'(err); dat = int'(rd_data);
    endtask

    int tk, oe, e, dat;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R13 idle oe", int'(line_oe), 0);
        chk("R13 idle level", int'(line_out), 1);
        chk("R1 idle clock", int'(link_clk), 0);
        chk("R11 idle done", int'(done), 0);
        chk("R11 idle err", int'(err), 0);

        // R5 R10: write acknowledge
        clear_stream(); add_resp(3, 2'd1, 2'd0, 0, 0, 0);
        run(0, 2'd2, 0, tk, oe, e, dat);
        chk("R5 R10 write ticks", tk, 3 + 5 + 4 + 100);
        chk("R5 write err", e, 0);
        @(negedge clk);
        chk("R11 done single", int'(done), 0);
        repeat (5) @(negedge clk);
        chk("R11 err held", int'(err), 0);

        // R4: each read size
        for (int s = 0; s < 3; s++) begin
            clear_stream(); add_resp(0, 2'd2, 2'd0, nb(2'(s)), 32'hC3A5_96E1, 0);
            run(1, 2'(s), 0, tk, oe, e, dat);
            chk("R4 read ticks", tk, 5 + nb(2'(s)) + 4 + 100);
            chk("R4 read data", dat, int'(32'hC3A5_96E1 & ((nb(2'(s)) == 32) ? 32'hFFFF_FFFF : ((32'h1 << nb(2'(s))) - 1))));
            chk("R4 read err", e, 0);
        end

        // R6: corrupted checksum still returns data
        clear_stream(); add_resp(4, 2'd0, 2'd0, 16, 32'h0000_BEEF, 1);
        run(1, 2'd1, 0, tk, oe, e, dat);
        chk("R6 mismatch err", e, 5);
        chk("R6 mismatch data", dat, 32'hBEEF);

        // R9: error responses
        clear_stream(); add_resp(5, 2'd3, 2'd2, 0, 0, 0);
        run(1, 2'd2, 0, tk, oe, e, dat);
        chk("R9 code2 err", e, 2);
        chk("R9 code2 ticks", tk, 5 + 5 + 20);
        clear_stream(); add_resp(0, 2'd0, 2'd3, 0, 0, 0);
        run(0, 2'd0, 0, tk, oe, e, dat);
        chk("R9 code3 err", e, 3);
        chk("R3 R9 code3 ticks", tk, 5 + 20);

        // R2: timeout boundary
        clear_stream();
        run(0, 2'd0, 0, tk, oe, e, dat);
        chk("R2 timeout err", e, 4);
        chk("R2 timeout ticks", tk, 1020);
        clear_stream(); add_resp(999, 2'd0, 2'd0, 0, 0, 0);
        run(0, 2'd0, 0, tk, oe, e, dat);
        chk("R2 late start err", e, 0);
        chk("R2 late start ticks", tk, 999 + 5 + 4 + 100);

        // R7: one busy, then acknowledge
        clear_stream(); add_resp(2, 2'd1, 2'd1, 0, 0, 0); add_resp(2, 2'd1, 2'd0, 0, 0, 0);
        run(0, 2'd0, 0, tk, oe, e, dat);
        chk("R7 busy err", e, 0);
        chk("R7 busy ticks", tk, (2 + 5 + 126) + (2 + 5 + 4 + 100));
        chk("R7 drive ticks", oe, 126);
        begin
            bit [9:0] frame;
            int bad;
            frame = {1'b1, 9'h02A};
            bad = 0;
            for (int i = 0; i < 126; i++) begin
                bit exp_b;
                exp_b = (i >= 100 && i < 110) ? frame[109 - i] : 1'b0;
                if (txlog[(oe_ticks - 126 + i) % 1024] != exp_b) bad++;
            end
            chk("R7 R13 poll frame bit errors", bad, 0);
        end

        // R8: retry limit
        clear_stream();
        for (int i = 0; i < 100; i++) add_resp(0, 2'd0, 2'd1, 0, 0, 0);
        add_resp(0, 2'd0, 2'd0, 0, 0, 0);
        run(0, 2'd0, 0, tk, oe, e, dat);
        chk("R8 100 busy ok", e, 0);
        chk("R8 100 polls", oe, 100 * 126);
        clear_stream();
        for (int i = 0; i < 101; i++) add_resp(0, 2'd0, 2'd1, 0, 0, 0);
        run(0, 2'd0, 0, tk, oe, e, dat);
        chk("R8 limit err", e, 1);
        chk("R8 limit ticks", tk, 100 * 131 + 5);
        chk("R8 limit polls", oe, 100 * 126);

        // R12: start mid-transaction ignored
        clear_stream(); add_resp(50, 2'd2, 2'd0, 0, 0, 0);
        run(0, 2'd0, 1, tk, oe, e, dat);
        chk("R12 ignored ticks", tk, 50 + 5 + 4 + 100);
        chk("R12 ignored data", dat, 0);

        // random mix
        void'($urandom(32'd1234));
        for (int n = 0; n < 40; n++) begin
            bit rd, bad;
            bit [1:0] sz, id;
            bit [31:0] v;
            int g, bits, xdat;
            rd = $urandom % 2; sz = 2'($urandom % 4); id = 2'($urandom % 4);
            v = $urandom; g = $urandom % 21; bad = (($urandom % 8) == 0);
            bits = rd ? nb(sz) : 0;
            clear_stream(); add_resp(g, id, 2'd0, bits, v, bad);
            run(rd, sz, 0, tk, oe, e, dat);
            xdat = (bits == 0) ? 0 : (bits == 32) ? int'(v) : int'(v & ((32'h1 << bits) - 1));
            chk("R3 R4 R6 random err", e, bad ? 5 : 0);
            chk("R4 random data", dat, xdat);
            chk("R10 random ticks", tk, g + 5 + bits + 4 + 100);
            if (hung) break;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule